// File: doc/BRIEF.md
# Register Pointer and Command Decoder for a Serial-Bus I/O Expander

This block sits between the byte-level engine of a two-wire serial slave and the register file of a multi-bank I/O expander. After each start event it examines the first byte (a 7-bit bus address plus a read/write flag). It decides whether the transaction is meant for this device, for a broadcast all-call address, or for neither. In write direction the next byte is a command byte. The command byte loads a register index and an auto-increment flag. Each further data byte then becomes a write strobe to the register file at the current index. In read direction each request from the byte engine becomes a read strobe at the current index.

The register space is laid out as groups of eight slots, and each group holds five banks. With auto-increment set, only the low three index bits step. They run through banks 0 to 4 and wrap to bank 0, so a burst never leaves its group and never touches the three unused slots. Indices above the five banked groups are single control registers, and the pointer holds on them. A watchdog counts how long either bus line stays low. When the limit is reached it returns the decoder to idle and flags the byte engine to reset.

Received bytes arrive on a valid/ready stream. The block never applies back-pressure: `rx_ready` is always high, so a byte is taken in the cycle `rx_valid` is high. Every accepted byte gets an `ack_vld` pulse one cycle later. Read requests (`tx_req`) are single-cycle pulses and are not held off.

Top module: `regptr_ctrl`

## Requirements
- R1: The own address is `{ADDR_HI, pin_code[5:0]}` (7 bits), compared with `rx_data[7:1]` of the first byte after a start. `rx_data[0]`=1 means read. On a match, the cycle after acceptance shows `ack_vld`=1 and `ack`=1, in either direction.
- R2: The all-call address `ALLCALL_ADDR` is acknowledged only in write direction and only while `allcall_en`=1. Afterwards it behaves like an own-address write. A read to it is never acknowledged.
- R3: If the first byte matches neither address, it and every later byte up to the next start give `ack`=0 and no strobe.
- R4: The byte after an acknowledged write address is the command byte: bit 7 is the auto-increment flag, bits 5:0 are the register index, and bit 6 is ignored. It is acknowledged and produces no strobe.
- R5: Each later data byte gives, one cycle after acceptance, `ack`=1, `wr_stb`=1, `wr_idx` equal to the current pointer and `wr_data` equal to the byte.
- R6: With the flag set and index bits 5:3 below 5, each write or read steps the pointer. Bits 2:0 go to 0 when they are 4 or more, and otherwise go up by one. Bits 5:3 stay unchanged.
- R7: With the flag clear, the pointer does not change across writes or reads.
- R8: With index bits 5:3 at 5 or above, the pointer holds even with the flag set.
- R9: In read direction each `tx_req` pulse gives, one cycle later, `rd_stb`=1 with `rd_idx` equal to the current pointer. A repeated start followed by a read address continues from the pointer left by the earlier write.
- R10: After a stop, accepted bytes give `ack`=0 and no strobe, and `tx_req` gives no read strobe, until the next start.
- R11: When `to_en`=1 and `scl_i` or `sda_i` is low for `PRESC*TO_TICKS` consecutive cycles, `bus_rst` pulses for one cycle after exactly that many edges, and the decoder returns to idle. A cycle with both lines high restarts the count. With `to_en`=0 no pulse occurs.
- R12: After reset all strobes, `ack_vld` and `bus_rst` are 0, and the decoder is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_code | input | 6 | Address code from the three address-select pins |
| allcall_en | input | 1 | Enable for answering the all-call address |
| to_en | input | 1 | Enable for the stuck-bus watchdog |
| scl_i | input | 1 | Sampled clock line level |
| sda_i | input | 1 | Sampled data line level |
| start_evt | input | 1 | Start or repeated-start event pulse |
| stop_evt | input | 1 | Stop event pulse |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Always high; the block never stalls |
| ack_vld | output | 1 | Acknowledge decision valid for the last accepted byte |
| ack | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| tx_req | input | 1 | Byte engine asks for the next read byte |
| rd_stb | output | 1 | Register-file read strobe |
| rd_idx | output | 6 | Read register index |
| wr_stb | output | 1 | Register-file write strobe |
| wr_idx | output | 6 | Write register index |
| wr_data | output | 8 | Write data |
| bus_rst | output | 1 | One-cycle stuck-bus reset pulse |

## Verification
The assertions assume that start and stop events are single-cycle pulses, that `rx_valid` and `tx_req` are never high in the same cycle, and that the line levels stay high outside the watchdog tests. The stimulus drives every event as a one-cycle pulse on the falling clock edge and never overlaps a received byte with a read request. The bench sweeps all 64 pin codes and all 64 command indices with the flag set and clear, and models the pointer stepping arithmetically.

// File: rtl/regptr_pkg.sv
package regptr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_CMD   = 3'd2,
    ST_WDATA = 3'd3,
    ST_READ  = 3'd4,
    ST_SKIP  = 3'd5
  } bus_st_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned AI_BIT = 7;
endpackage

// File: rtl/regptr_addr_match.sv
module regptr_addr_match #(
  parameter logic       ADDR_HI      = 1'b0,
  parameter logic [6:0] ALLCALL_ADDR = 7'h68
) (
  input  logic [7:0] addr_byte,
  input  logic [5:0] pin_code,
  input  logic       allcall_en,
  output logic       own_hit,
  output logic       ac_hit,
  output logic       is_read
);
  logic [6:0] own_addr;
  logic [6:0] rx_addr;

  assign own_addr = {ADDR_HI, pin_code};
  assign rx_addr  = addr_byte[7:1];
  assign is_read  = addr_byte[0];
  assign own_hit  = (rx_addr == own_addr);
  // broadcast answered only for writes and only when enabled
  assign ac_hit   = allcall_en && !is_read && (rx_addr == ALLCALL_ADDR);
endmodule

// File: rtl/regptr_step.sv
module regptr_step #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned NBANK  = 5,
  parameter int unsigned NGRP   = 5
) (
  input  logic [IDX_W-1:0] cur,
  input  logic             ai,
  output logic [IDX_W-1:0] nxt
);
  localparam int unsigned GRP_W = IDX_W - BANK_W;
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NBANK - 1);
  localparam logic [GRP_W-1:0]  GRP_LIM   = GRP_W'(NGRP);

  logic [GRP_W-1:0]  grp;
  logic [BANK_W-1:0] bank;
  logic [BANK_W-1:0] bank_nxt;
  logic              banked;

  assign grp    = cur[IDX_W-1:BANK_W];
  assign bank   = cur[BANK_W-1:0];
  assign banked = (grp < GRP_LIM);

  always_comb begin
    if (bank >= LAST_BANK) bank_nxt = '0;
    else                   bank_nxt = bank + 1'b1;
  end

  always_comb begin
    if (ai && banked) nxt = {grp, bank_nxt};
    else              nxt = cur;
  end
endmodule

// File: rtl/regptr_bus_watchdog.sv
module regptr_bus_watchdog #(
  parameter int unsigned PRESC    = 1000,
  parameter int unsigned TO_TICKS = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl_i,
  input  logic sda_i,
  output logic expire
);
  localparam int unsigned PW = (PRESC > 2) ? $clog2(PRESC) : 1;
  localparam int unsigned CW = (TO_TICKS > 2) ? $clog2(TO_TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESC - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TO_TICKS - 1);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          line_low;
  logic          tick;

  assign line_low = en && !(scl_i && sda_i);
  assign tick     = line_low && (pre_q == PRE_LAST);
  assign expire   = tick && (cnt_q == CNT_LAST) && !done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!line_low) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tick) begin
      pre_q <= '0;
      if (expire) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else if (!done_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  AST_EXPIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R11
  AST_EXPIRE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(line_low)); // R11
endmodule

// File: rtl/regptr_ctrl.sv
module regptr_ctrl #(
  parameter logic        ADDR_HI      = 1'b0,
  parameter logic [6:0]  ALLCALL_ADDR = 7'h68,
  parameter int unsigned IDX_W        = 6,
  parameter int unsigned BANK_W       = 3,
  parameter int unsigned NBANK        = 5,
  parameter int unsigned NGRP         = 5,
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned TO_MS        = 25,
  parameter int unsigned PRESC        = 1000,
  parameter int unsigned TO_TICKS     = CLK_HZ / 1000 * TO_MS / PRESC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       pin_code,
  input  logic             allcall_en,
  input  logic             to_en,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             ack_vld,
  output logic             ack,
  input  logic             tx_req,
  output logic             rd_stb,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_stb,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             bus_rst
);
  import regptr_pkg::*;

  localparam int unsigned GRP_W = IDX_W - BANK_W;
  localparam logic [GRP_W-1:0]  GRP_LIM = GRP_W'(NGRP);
  localparam logic [BANK_W-1:0] BANK_LIM = BANK_W'(NBANK);

  bus_st_e          st_q;
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_nxt;
  logic             ai_q;
  logic             own_hit, ac_hit, is_read;
  logic             expire;
  logic             quiet;
  logic             wr_go, rd_go, adv_c;

  assign rx_ready = 1'b1;

  regptr_addr_match #(
    .ADDR_HI(ADDR_HI), .ALLCALL_ADDR(ALLCALL_ADDR)
  ) u_match (
    .addr_byte(rx_data), .pin_code(pin_code), .allcall_en(allcall_en),
    .own_hit(own_hit), .ac_hit(ac_hit), .is_read(is_read)
  );

  regptr_step #(
    .IDX_W(IDX_W), .BANK_W(BANK_W), .NBANK(NBANK), .NGRP(NGRP)
  ) u_step (
    .cur(ptr_q), .ai(ai_q), .nxt(ptr_nxt)
  );

  regptr_bus_watchdog #(
    .PRESC(PRESC), .TO_TICKS(TO_TICKS)
  ) u_wdog (
    .clk(clk), .rst_n(rst_n), .en(to_en), .scl_i(scl_i), .sda_i(sda_i),
    .expire(expire)
  );

  // no bus event overrides byte handling this cycle
  assign quiet = !expire && !start_evt && !stop_evt;
  assign wr_go = quiet && rx_valid && (st_q == ST_WDATA);
  assign rd_go = quiet && tx_req && (st_q == ST_READ);
  assign adv_c = wr_go || rd_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      ai_q    <= 1'b0;
      ack_vld <= 1'b0;
      ack     <= 1'b0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      rd_stb  <= 1'b0;
      rd_idx  <= '0;
      bus_rst <= 1'b0;
    end else begin
      ack_vld <= 1'b0;
      ack     <= 1'b0;
      wr_stb  <= 1'b0;
      rd_stb  <= 1'b0;
      bus_rst <= expire;
      if (expire) begin
        st_q <= ST_IDLE;
      end else if (start_evt) begin
        st_q <= ST_ADDR;
      end else if (stop_evt) begin
        st_q <= ST_IDLE;
      end else begin
        if (rx_valid) begin
          ack_vld <= 1'b1;
          unique case (st_q)
            ST_ADDR: begin
              if (own_hit) begin
                ack  <= 1'b1;
                st_q <= is_read ? ST_READ : ST_CMD;
              end else if (ac_hit) begin
                ack  <= 1'b1;
                st_q <= ST_CMD;
              end else begin
                st_q <= ST_SKIP;
              end
            end
            ST_CMD: begin
              ack   <= 1'b1;
              ai_q  <= rx_data[AI_BIT];
              ptr_q <= rx_data[IDX_W-1:0];
              st_q  <= ST_WDATA;
            end
            ST_WDATA: begin
              ack     <= 1'b1;
              wr_stb  <= 1'b1;
              wr_idx  <= ptr_q;
              wr_data <= rx_data;
              ptr_q   <= ptr_nxt;
            end
            default: ack <= 1'b0;
          endcase
        end
        if (rd_go) begin
          rd_stb <= 1'b1;
          rd_idx <= ptr_q;
          ptr_q  <= ptr_nxt;
        end
      end
    end
  end

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb)); // R5
  AST_WR_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(rx_valid) && ack && ack_vld); // R5
  AST_RD_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> $past(tx_req)); // R9
  AST_WRAP_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_c && ai_q && (ptr_q[IDX_W-1:BANK_W] < GRP_LIM) |=>
      (ptr_q[BANK_W-1:0] < BANK_LIM) &&
      (ptr_q[IDX_W-1:BANK_W] == $past(ptr_q[IDX_W-1:BANK_W]))); // R6
  AST_HOLD_NO_AI: assert property (@(posedge clk) disable iff (!rst_n)
    adv_c && !ai_q |=> $stable(ptr_q)); // R7
  AST_HOLD_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    adv_c && (ptr_q[IDX_W-1:BANK_W] >= GRP_LIM) |=> $stable(ptr_q)); // R8
  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt && !start_evt |=> !wr_stb && !rd_stb && !ack); // R10
  AST_TO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !to_en |=> !bus_rst); // R11
  AST_TO_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    scl_i && sda_i |=> !bus_rst); // R11
endmodule

// File: tb/regptr_ctrl_tb_top.sv
module regptr_ctrl_tb_top;
  localparam int P = 4;
  localparam int T = 10;
  localparam logic [6:0] AC = 7'h68;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] pin_code = '0;
  logic allcall_en = 1'b0, to_en = 1'b1, scl_i = 1'b1, sda_i = 1'b1;
  logic start_evt = 1'b0, stop_evt = 1'b0, rx_valid = 1'b0, tx_req = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready, ack_vld, ack, rd_stb, wr_stb, bus_rst;
  logic [5:0] rd_idx, wr_idx;
  logic [7:0] wr_data;

  int vec = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  regptr_ctrl #(.ADDR_HI(1'b0), .ALLCALL_ADDR(AC), .PRESC(P), .TO_TICKS(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_code(pin_code), .allcall_en(allcall_en),
    .to_en(to_en), .scl_i(scl_i), .sda_i(sda_i), .start_evt(start_evt),
    .stop_evt(stop_evt), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .ack_vld(ack_vld), .ack(ack), .tx_req(tx_req),
    .rd_stb(rd_stb), .rd_idx(rd_idx), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .wr_data(wr_data), .bus_rst(bus_rst));

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int step(input int p, input bit ai);
    int g = p / 8;
    int b = p % 8;
    if (!ai || g >= 5) return p;
    return (b >= 4) ? g * 8 : p + 1;
  endfunction

  task automatic do_start();
    @(negedge clk) start_evt = 1'b1;
    @(negedge clk) start_evt = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_evt = 1'b1;
    @(negedge clk) stop_evt = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output bit a, output bit w,
                      output int wi, output int wd);
    @(negedge clk) begin rx_valid = 1'b1; rx_data = b; end
    @(negedge clk) rx_valid = 1'b0;
    a = ack_vld && ack; w = wr_stb; wi = int'(wr_idx); wd = int'(wr_data);
  endtask

  task automatic req(output bit r, output int ri);
    @(negedge clk) tx_req = 1'b1;
    @(negedge clk) tx_req = 1'b0;
    r = rd_stb; ri = int'(rd_idx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; vec++;
      $display("FAIL watchdog: got 0 expected 1 (run finished)");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    bit a, w, r;
    int wi, wd, ri, p, k, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 wr_stb", wr_stb, 0); chk("R12 rd_stb", rd_stb, 0);
    chk("R12 ack_vld", ack_vld, 0); chk("R12 bus_rst", bus_rst, 0);
    chk("R12 rx_ready", rx_ready, 1);
    send(8'h55, a, w, wi, wd);
    chk("R12 idle byte ack", a, 0); chk("R12 idle byte strobe", w, 0);

    // R1 / R3 address sweep over all pin codes
    for (int c = 0; c < 64; c++) begin
      pin_code = 6'(c);
      do_start(); send({1'b0, 6'(c), 1'b0}, a, w, wi, wd);
      chk("R1 own write ack", a, 1);
      do_start(); send({1'b0, 6'(c), 1'b1}, a, w, wi, wd);
      chk("R1 own read ack", a, 1);
      do_start(); send({1'b0, 6'(c ^ 1), 1'b0}, a, w, wi, wd);
      chk("R3 foreign addr nack", a, 0);
      send(8'h80, a, w, wi, wd);
      chk("R3 later byte nack", a, 0); chk("R3 later byte no strobe", w, 0);
      do_stop();
    end
    pin_code = 6'h15;

    // R4..R9 pointer sweep over every index and flag value
    for (int idx = 0; idx < 64; idx++) begin
      for (int ai = 0; ai < 2; ai++) begin
        do_start(); send({1'b0, 6'h15, 1'b0}, a, w, wi, wd);
        send({1'(ai), 1'(idx % 2), 6'(idx)}, a, w, wi, wd);
        chk("R4 cmd ack", a, 1); chk("R4 cmd no strobe", w, 0);
        p = idx;
        for (int n = 0; n < 3; n++) begin
          send(8'((idx * 7 + n) & 255), a, w, wi, wd);
          chk("R5 wr ack", a, 1); chk("R5 wr_stb", w, 1);
          chk(ai ? "R6 wr_idx step" : "R7 wr_idx hold", wi, p);
          chk("R5 wr_data", wd, (idx * 7 + n) & 255);
          p = step(p, 1'(ai));
        end
        do_start(); send({1'b0, 6'h15, 1'b1}, a, w, wi, wd);
        for (int n = 0; n < 2; n++) begin
          req(r, ri);
          chk("R9 rd_stb", r, 1);
          chk(idx >= 40 ? "R8 rd_idx ctrl hold" : "R9 rd_idx continue", ri, p);
          p = step(p, 1'(ai));
        end
        do_stop();
      end
    end

    // R2 all-call
    allcall_en = 1'b0;
    do_start(); send({AC, 1'b0}, a, w, wi, wd);
    chk("R2 allcall disabled nack", a, 0);
    allcall_en = 1'b1;
    do_start(); send({AC, 1'b0}, a, w, wi, wd);
    chk("R2 allcall write ack", a, 1);
    send(8'h0B, a, w, wi, wd);
    send(8'hA5, a, w, wi, wd);
    chk("R2 allcall wr_stb", w, 1); chk("R2 allcall wr_idx", wi, 11);
    do_start(); send({AC, 1'b1}, a, w, wi, wd);
    chk("R2 allcall read nack", a, 0);
    do_stop();

    // R10 bytes and requests after stop
    do_start(); send({1'b0, 6'h15, 1'b0}, a, w, wi, wd);
    send(8'h88, a, w, wi, wd);
    do_stop();
    send(8'h12, a, w, wi, wd);
    chk("R10 after stop ack", a, 0); chk("R10 after stop strobe", w, 0);
    req(r, ri);
    chk("R10 after stop rd_stb", r, 0);

    // R11 timeout fires after exactly P*T edges of a low line
    do_start(); send({1'b0, 6'h15, 1'b0}, a, w, wi, wd);
    send(8'h08, a, w, wi, wd);
    @(negedge clk) scl_i = 1'b0;
    seen = 0;
    for (k = 1; k <= 3 * P * T; k++) begin
      @(negedge clk);
      if (bus_rst && seen == 0) seen = k;
    end
    chk("R11 timeout edge count", seen, P * T);
    scl_i = 1'b1;
    send(8'h33, a, w, wi, wd);
    chk("R11 idle after timeout ack", a, 0); chk("R11 no strobe after timeout", w, 0);

    // R11 lines high restart the count
    @(negedge clk) sda_i = 1'b0;
    seen = 0;
    for (k = 1; k < P * T; k++) begin
      @(negedge clk); if (bus_rst) seen = 1;
    end
    sda_i = 1'b1;
    @(negedge clk) sda_i = 1'b0;
    for (k = 1; k <= 2 * P * T; k++) begin
      @(negedge clk);
      if (bus_rst && seen == 0) seen = k;
    end
    chk("R11 restart after high", seen, P * T);
    sda_i = 1'b1;

    // R11 disabled watchdog
    to_en = 1'b0;
    @(negedge clk) scl_i = 1'b0;
    seen = 0;
    for (k = 1; k <= 3 * P * T; k++) begin
      @(negedge clk); if (bus_rst) seen = 1;
    end
    chk("R11 disabled no pulse", seen, 0);
    scl_i = 1'b1; to_en = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule